// File: doc/BRIEF.md
# Master Reset Sequencer

This block gathers every reset request of a small microcontroller core into a single master reset that software cannot mask. The requests are power-on, a brown-out trip, a watchdog expiry, a fault flag from the external clock supervisor, and an active-low reset pin. The analog comparators and supply sensing sit outside the block and reach it as digital flags. A brown-out trip counts only while the core is out of power-down. Power-down means the core is sleeping and the peripheral clock is stopped. A threshold-select bit chosen by software is passed through to the brown-out comparator.

Master reset asserts at once, without waiting for a clock edge. Its release is timed. Once every request has gone quiet, a two-flop synchronizer delays the release. After that, a stretch counter clocked at one quarter of the system clock must count a set number of ticks. While reset is held, the block does three things: it keeps the interrupt state cleared, it holds the peripheral bus in its reset mode, and it forces every bidirectional port direction bit to input. In the first cycle after release it sends the core one strobe. That strobe carries a short-call opcode and a fixed initialization address. A sticky cause register records which requests occurred.

Top module: `mrst_sequencer`

## Requirements
- R1: Any active request forces `mrst_o` high in the same cycle, before the next clock edge. Active means `por_i`, an effective brown-out, `wdt_expire_i` or `clk_fault_i` high, or `ext_rst_n_i` low.
- R2: A brown-out trip has no effect while `core_sleep_i` and `pclk_stop_i` are both high: it raises no reset and sets no cause bit. If either of those inputs is low, the trip acts as a request.
- R3: Once every request is inactive, `mrst_o` falls at rising edge number 2 + STRETCH_TICKS*2^DIV_LOG2, counted from the first edge after the requests went away. With the defaults that is edge 66.
- R4: A request that returns while the release is being timed restarts the whole delay of R3, counted from its own removal.
- R5: While `mrst_o` is high, `irq_clr_o` and `iobus_rst_o` are high and `port_dir_o` is all zeros (input). While it is low, those two outputs are low and `port_dir_o` equals `port_dir_i`.
- R6: `call_valid_o` is high for exactly one cycle per release: the first cycle in which `mrst_o` is low. In that cycle `call_opcode_o` is 0xC1 and `call_addr_o` is 0x008. In every other cycle both buses are zero.
- R7: Cause bits are: bit 0 power-on, bit 1 brown-out, bit 2 watchdog, bit 3 clock supervisor, bit 4 reset pin. A bit is set at every edge where its request is sampled active. A power-on request clears all the other bits.
- R8: A write with `cause_clr_we_i` high clears the cause bits marked by ones in `cause_clr_mask_i`, but only while `mrst_o` is low. During reset such a write is ignored. An active request wins over a clear of its own bit.
- R9: `bod_sel_o` equals `bod_sel_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on request, active high |
| bod_trip_i | input | 1 | Brown-out comparator trip |
| wdt_expire_i | input | 1 | Watchdog time-out |
| clk_fault_i | input | 1 | External clock supervisor fault |
| ext_rst_n_i | input | 1 | Reset pin, active low |
| core_sleep_i | input | 1 | Core is in sleep |
| pclk_stop_i | input | 1 | Peripheral clock stopped |
| bod_sel_i | input | 1 | Software threshold select |
| cause_clr_we_i | input | 1 | Cause clear write strobe |
| cause_clr_mask_i | input | 5 | Write-one-to-clear mask for cause bits |
| port_dir_i | input | PORT_W | Port direction from software, 1 = output |
| mrst_o | output | 1 | Master reset |
| irq_clr_o | output | 1 | Clears interrupt enable, pending and active state |
| iobus_rst_o | output | 1 | Peripheral bus reset mode |
| port_dir_o | output | PORT_W | Gated port direction |
| bod_sel_o | output | 1 | Threshold select to comparator |
| cause_o | output | 5 | Sticky reset cause bits |
| call_valid_o | output | 1 | One-cycle call injection strobe |
| call_opcode_o | output | 8 | Injected opcode |
| call_addr_o | output | VEC_W | Injected call target |

## Verification
The assertions check four things on every cycle. Any request must find reset already high. A release must come exactly the full stretch after the last request. The call strobe must be a lone pulse on a falling reset edge. Cause bits may rise or fall only for a permitted reason. The scenarios cover what only end-to-end sequences can show. These are the exact release edge and its restart after a glitch, the brown-out gating under each combination of power-down flags, and clear writes being ignored during reset. They also cover the values of the port and interrupt gates before and after release.

// File: rtl/mrst_pkg.sv
package mrst_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_POR = 0;
  localparam int SRC_BOD = 1;
  localparam int SRC_WDT = 2;
  localparam int SRC_CKS = 3;
  localparam int SRC_PIN = 4;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/mrst_req_merge.sv
module mrst_req_merge
  import mrst_pkg::*;
(
  input  logic     clk,
  input  logic     por_i,
  input  logic     bod_trip_i,
  input  logic     wdt_expire_i,
  input  logic     clk_fault_i,
  input  logic     ext_rst_n_i,
  input  logic     core_sleep_i,
  input  logic     pclk_stop_i,
  input  logic     mrst_i,
  input  logic     clr_we_i,
  input  src_vec_t clr_mask_i,
  output logic     any_req_o,
  output src_vec_t cause_o
);
  logic     pwr_down;
  src_vec_t req;
  src_vec_t clr_eff;
  src_vec_t cause_q;

  // Brown-out sensing is off while the core sleeps with its peripheral clock stopped
  assign pwr_down = core_sleep_i & pclk_stop_i;

  always_comb begin
    req          = '0;
    req[SRC_POR] = por_i;
    req[SRC_BOD] = bod_trip_i & ~pwr_down;
    req[SRC_WDT] = wdt_expire_i;
    req[SRC_CKS] = clk_fault_i;
    req[SRC_PIN] = ~ext_rst_n_i;
  end

  assign any_req_o = |req;
  assign clr_eff   = (clr_we_i && !mrst_i) ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (req[SRC_POR]) begin
      cause_q          <= '0;
      cause_q[SRC_POR] <= 1'b1;
    end else begin
      cause_q <= (cause_q & ~clr_eff) | req;
    end
  end

  assign cause_o = cause_q;

  a_r2_bod_gated: assert property (@(posedge clk) disable iff (por_i)
    $rose(cause_q[SRC_BOD]) |-> $past(bod_trip_i && !(core_sleep_i && pclk_stop_i)));

  for (genvar i = 1; i < NSRC; i++) begin : g_clr_chk
    a_r8_clear_only_released: assert property (@(posedge clk) disable iff (por_i)
      $fell(cause_q[i]) |-> $past(clr_we_i && clr_mask_i[i] && !mrst_i));
  end
endmodule

// File: rtl/mrst_stretch.sv
module mrst_stretch #(
  parameter int TICKS    = 16,
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic any_req_i,
  output logic mrst_o,
  output logic release_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic                sync1, sync2, mrst_q;
  logic [DIV_LOG2-1:0] pre_q;
  logic [CW-1:0]       tick_cnt;
  logic                tick, last_tick, timing;

  assign tick      = &pre_q;
  assign last_tick = tick && (tick_cnt == CW'(TICKS - 1));
  assign timing    = mrst_q && !sync2;

  // Asynchronous set on any request, synchronous two-stage release
  always_ff @(posedge clk or posedge any_req_i) begin
    if (any_req_i) begin
      sync1  <= 1'b1;
      sync2  <= 1'b1;
      mrst_q <= 1'b1;
    end else begin
      sync1 <= 1'b0;
      sync2 <= sync1;
      if (timing && last_tick) mrst_q <= 1'b0;
    end
  end

  // Quarter-rate prescaler and stretch counter, held clear unless timing
  always_ff @(posedge clk) begin
    if (!timing) begin
      pre_q    <= '0;
      tick_cnt <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign mrst_o    = mrst_q;
  assign release_o = timing && last_tick;
endmodule

// File: rtl/mrst_vector.sv
module mrst_vector #(
  parameter int          VEC_W    = 12,
  parameter logic [7:0]  CALL_OPC = 8'hC1,
  parameter logic [11:0] CALL_VEC = 12'h008
) (
  input  logic             clk,
  input  logic             release_i,
  output logic             call_valid_o,
  output logic [7:0]       call_opcode_o,
  output logic [VEC_W-1:0] call_addr_o
);
  always_ff @(posedge clk) begin
    call_valid_o  <= release_i;
    call_opcode_o <= release_i ? CALL_OPC : 8'h00;
    call_addr_o   <= release_i ? VEC_W'(CALL_VEC) : '0;
  end
endmodule

// File: rtl/mrst_sequencer.sv
module mrst_sequencer
  import mrst_pkg::*;
#(
  parameter int          PORT_W        = 8,
  parameter int          VEC_W         = 12,
  parameter int          STRETCH_TICKS = 16,
  parameter int          DIV_LOG2      = 2,
  parameter logic [7:0]  CALL_OPC      = 8'hC1,
  parameter logic [11:0] CALL_VEC      = 12'h008
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              bod_trip_i,
  input  logic              wdt_expire_i,
  input  logic              clk_fault_i,
  input  logic              ext_rst_n_i,
  input  logic              core_sleep_i,
  input  logic              pclk_stop_i,
  input  logic              bod_sel_i,
  input  logic              cause_clr_we_i,
  input  logic [4:0]        cause_clr_mask_i,
  input  logic [PORT_W-1:0] port_dir_i,
  output logic              mrst_o,
  output logic              irq_clr_o,
  output logic              iobus_rst_o,
  output logic [PORT_W-1:0] port_dir_o,
  output logic              bod_sel_o,
  output logic [4:0]        cause_o,
  output logic              call_valid_o,
  output logic [7:0]        call_opcode_o,
  output logic [VEC_W-1:0]  call_addr_o
);
  localparam int REL_EDGE = 2 + STRETCH_TICKS * (1 << DIV_LOG2);
  localparam int QW       = $clog2(REL_EDGE + 1);

  logic any_req, mrst, release_now;

  mrst_req_merge u_merge (
    .clk          (clk),
    .por_i        (por_i),
    .bod_trip_i   (bod_trip_i),
    .wdt_expire_i (wdt_expire_i),
    .clk_fault_i  (clk_fault_i),
    .ext_rst_n_i  (ext_rst_n_i),
    .core_sleep_i (core_sleep_i),
    .pclk_stop_i  (pclk_stop_i),
    .mrst_i       (mrst),
    .clr_we_i     (cause_clr_we_i),
    .clr_mask_i   (cause_clr_mask_i),
    .any_req_o    (any_req),
    .cause_o      (cause_o)
  );

  mrst_stretch #(.TICKS(STRETCH_TICKS), .DIV_LOG2(DIV_LOG2)) u_stretch (
    .clk       (clk),
    .any_req_i (any_req),
    .mrst_o    (mrst),
    .release_o (release_now)
  );

  mrst_vector #(.VEC_W(VEC_W), .CALL_OPC(CALL_OPC), .CALL_VEC(CALL_VEC)) u_vector (
    .clk           (clk),
    .release_i     (release_now),
    .call_valid_o  (call_valid_o),
    .call_opcode_o (call_opcode_o),
    .call_addr_o   (call_addr_o)
  );

  // Reset-time forcing must follow the asynchronous assert, so it stays combinational
  assign mrst_o      = mrst;
  assign irq_clr_o   = mrst;
  assign iobus_rst_o = mrst;
  assign port_dir_o  = mrst ? '0 : port_dir_i;

  always_ff @(posedge clk) bod_sel_o <= bod_sel_i;

  // Quiet-edge counter used to check the release window
  logic [QW-1:0] quiet_cnt;
  always_ff @(posedge clk) begin
    if (any_req)                         quiet_cnt <= '0;
    else if (quiet_cnt != QW'(REL_EDGE)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  a_r1_req_holds_reset: assert property (@(posedge clk) disable iff (por_i)
    any_req |-> mrst_o);

  a_r3_full_stretch: assert property (@(posedge clk) disable iff (por_i)
    $fell(mrst_o) |-> (quiet_cnt == QW'(REL_EDGE)));

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (por_i)
    call_valid_o |=> !call_valid_o);

  a_r6_strobe_on_release: assert property (@(posedge clk) disable iff (por_i)
    call_valid_o |-> (!mrst_o && $past(mrst_o)));
endmodule

// File: tb/sim_mrst_sequencer.sv
module sim_mrst_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 5;
  localparam int DLOG       = 2;
  localparam int PW         = 8;
  localparam int VW         = 12;
  localparam int REL        = 2 + TICKS * (1 << DLOG);

  logic clk = 1'b0;
  logic por = 1'b1, bod = 1'b0, wdt = 1'b0, cks = 1'b0, pin_n = 1'b1;
  logic slp = 1'b0, pstop = 1'b0, sel = 1'b0, clr_we = 1'b0;
  logic [4:0]    clr_mask = '0;
  logic [PW-1:0] pdir = 8'hA5;
  logic mrst, irqc, iob, selo, cv;
  logic [PW-1:0] pdir_o;
  logic [4:0]    cause;
  logic [7:0]    opc;
  logic [VW-1:0] addr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrst_sequencer #(.PORT_W(PW), .VEC_W(VW), .STRETCH_TICKS(TICKS), .DIV_LOG2(DLOG)) u0 (
    .clk(clk), .por_i(por), .bod_trip_i(bod), .wdt_expire_i(wdt), .clk_fault_i(cks),
    .ext_rst_n_i(pin_n), .core_sleep_i(slp), .pclk_stop_i(pstop), .bod_sel_i(sel),
    .cause_clr_we_i(clr_we), .cause_clr_mask_i(clr_mask), .port_dir_i(pdir),
    .mrst_o(mrst), .irq_clr_o(irqc), .iobus_rst_o(iob), .port_dir_o(pdir_o),
    .bod_sel_o(selo), .cause_o(cause), .call_valid_o(cv), .call_opcode_o(opc),
    .call_addr_o(addr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [4:0] src_bit(input int s);
    return 5'(1) << s;
  endfunction

  function automatic logic [PW-1:0] exp_dir(input logic r, input logic [PW-1:0] d);
    return r ? '0 : d;
  endfunction

  // Requests were just removed; walk to the release edge and check it
  task automatic expect_release();
    for (int k = 1; k <= REL; k++) begin
      step();
      if (k == REL - 1) begin
        chk(mrst == 1'b1, "R3 held before edge", 32'(mrst), 1);
        chk(pdir_o == exp_dir(1'b1, pdir) && irqc && iob, "R5 forced in reset", 32'(pdir_o), 0);
        chk(cv == 1'b0, "R6 no early strobe", 32'(cv), 0);
      end
    end
    chk(mrst == 1'b0, "R3 release edge", 32'(mrst), 0);
    chk(cv == 1'b1 && opc == 8'hC1 && addr == 12'h008, "R6 call strobe",
        {cv, 3'b0, opc, 8'b0, addr}, {1'b1, 3'b0, 8'hC1, 8'b0, 12'h008});
    chk(pdir_o == exp_dir(1'b0, pdir) && !irqc && !iob, "R5 released", 32'(pdir_o), 32'(pdir));
    step();
    chk(cv == 1'b0 && opc == 8'h00 && addr == '0, "R6 strobe once", {cv, opc}, 0);
  endtask

  task automatic clear_cause(input logic [4:0] m);
    clr_we = 1'b1; clr_mask = m;
    step();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic drive_src(input int s, input logic v);
    case (s)
      0: por = v;
      1: bod = v;
      2: wdt = v;
      3: cks = v;
      default: pin_n = ~v;
    endcase
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic prev_sel;
    seed = $urandom(32'd20240611);
    #1;
    repeat (4) step();
    chk(mrst && irqc && iob, "R1 power-on reset state", 32'(mrst), 1);
    chk(pdir_o == '0, "R5 ports input in reset", 32'(pdir_o), 0);
    chk(cause == src_bit(0), "R7 power-on cause", 32'(cause), 1);
    chk(cv == 1'b0, "R6 idle strobe", 32'(cv), 0);
    por = 1'b0;
    expect_release();
    chk(cause == src_bit(0), "R7 cause survives release", 32'(cause), 1);
    clear_cause(5'b00001);
    chk(cause == 5'b0, "R8 clear after release", 32'(cause), 0);

    // R1: pin reset takes effect without a clock edge
    pin_n = 1'b0;
    #1;
    chk(mrst == 1'b1, "R1 asynchronous assert", 32'(mrst), 1);
    step(); step();
    pin_n = 1'b1;
    expect_release();
    chk(cause == src_bit(4), "R7 pin cause bit4", 32'(cause), 32'(src_bit(4)));

    // R8: clear ignored during reset
    wdt = 1'b1;
    step();
    clear_cause(5'b11111);
    chk(cause == 5'b10100, "R8 clear ignored in reset", 32'(cause), 32'h14);
    wdt = 1'b0;
    expect_release();
    clear_cause(5'b11111);
    chk(cause == 5'b0, "R8 clear all", 32'(cause), 0);

    // R4: reassertion restarts the delay
    cks = 1'b1;
    step(); step();
    cks = 1'b0;
    repeat (REL - 3) step();
    chk(mrst == 1'b1, "R4 still timing", 32'(mrst), 1);
    cks = 1'b1;
    step();
    cks = 1'b0;
    expect_release();
    chk(cause == src_bit(3), "R7 supervisor cause bit3", 32'(cause), 32'(src_bit(3)));
    clear_cause(5'b11111);

    // R2: brown-out in power-down is ignored
    slp = 1'b1; pstop = 1'b1; bod = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (i == 5) begin
        chk(mrst == 1'b0 && !cv, "R2 gated no reset", 32'(mrst), 0);
        chk(cause == 5'b0, "R2 gated no cause", 32'(cause), 0);
        chk(pdir_o == pdir, "R2 ports untouched", 32'(pdir_o), 32'(pdir));
      end
    end
    pstop = 1'b0;
    #1;
    chk(mrst == 1'b1, "R2 active when clock runs", 32'(mrst), 1);
    step(); step();
    bod = 1'b0; slp = 1'b0;
    expect_release();
    chk(cause == src_bit(1), "R2 brown-out cause bit1", 32'(cause), 2);
    clear_cause(5'b11111);

    // R9: threshold select pass-through
    prev_sel = sel;
    for (int i = 0; i < 8; i++) begin
      sel = 1'($urandom());
      prev_sel = sel;
      step();
      chk(selo == prev_sel, "R9 select delay", 32'(selo), 32'(prev_sel));
    end

    // Random sources with random power-down flags
    for (int it = 0; it < 24; it++) begin
      int s;
      int h;
      logic gated;
      s = int'($urandom() % 5);
      h = 1 + int'($urandom() % 4);
      pdir = 8'($urandom());
      slp = 1'($urandom()); pstop = 1'($urandom());
      gated = (s == 1) && slp && pstop;
      drive_src(s, 1'b1);
      repeat (h) step();
      drive_src(s, 1'b0);
      if (gated) begin
        step();
        chk(mrst == 1'b0 && cause == 5'b0, "R2 random gated", {mrst, cause}, 0);
        chk(pdir_o == pdir, "R5 random idle ports", 32'(pdir_o), 32'(pdir));
      end else begin
        slp = 1'b0; pstop = 1'b0;
        expect_release();
        chk(cause == src_bit(s), "R7 random cause", 32'(cause), 32'(src_bit(s)));
      end
      slp = 1'b0; pstop = 1'b0;
      clear_cause(5'b11111);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule